// File: doc/BRIEF.md
# Sixteen-Bit Compare/Capture Timer

This block is a free-running or waveform-generating counter with a set of channels, each working either as a compare unit or as a capture unit. The counter moves one step on every cycle where the count-enable input `tick` is high. Four waveform modes are available. Two use the period register as the count ceiling, one uses channel 0's register as the ceiling, and one counts up and back down. The block reports the bottom, ceiling, all-ones and update conditions as levels on the ports.

Software-side writes arrive on a simple address/data strobe. Period and compare values are written into shadow copies. These copies move into the active registers only on an update step, so a running period never sees a half-changed setting. A combinational read port returns the control word, the active period, the flags, the count and each channel's active register.

Channels can be configured as four or as two. Waveform outputs sit on consecutive bits in channel order.

Top module: `cc_timer`

## Requirements
- R1: In modes 0, 1 and 2, each cycle with `tick` high and no count load adds one to the count, and the count goes to 0 instead when it equals the ceiling. With `tick` low the count holds.
- R2: The ceiling is the active period in modes 0, 2 and 3, and channel 0's active register in mode 1. The mode is control bits [1:0] at address 0.
- R3: In mode 3 the count rises to the ceiling and then falls. On a tick at the ceiling while rising, it turns and decrements. On a tick at 0 while falling, it turns and increments.
- R4: `bottom_o` is high when the count is 0, `top_o` when it equals the ceiling, and `max_o` when it is 16'hFFFF, whatever the ceiling. `update_o` follows `bottom_o` in mode 3 and `top_o` in the other modes.
- R5: Writes to address 1 (period) and to address 8+n (channel n) go to shadow registers. The active values change only on a tick while `update_o` is high. The read port returns the active values.
- R6: `ovf_o` is set on every tick taken while `update_o` is high. Writing 1 to bit 0 at address 2 clears it. A set in the same cycle as a clear takes priority.
- R7: A compare-mode channel's `cmp_flag_o` bit is set on a tick where the count equals its active register. Writing 1 to bit 4+n at address 2 clears it.
- R8: In modes 0 and 1, an enabled compare output toggles on each matching tick. Output enable for channel n is control bit 8+n.
- R9: In mode 2, an enabled output is set on a tick at count 0 and cleared on a tick at its compare value. The clear wins when both apply.
- R10: In mode 3, an enabled output is cleared on a rising-count match and set on a falling-count match.
- R11: Control bit 4+n selects capture for channel n. A `cap_strobe` pulse copies the count into the channel's active register and sets its `cap_flag_o` bit, which is cleared by writing 1 to bit 8+n at address 2. A capture channel ignores shadow copies and drives its output low.
- R12: A write to address 3 loads the count and sets the direction to rising. This overrides a tick in the same cycle, and that tick has no other effect.
- R13: After reset the count, the direction, the flags, the outputs, the control word, and the active and shadow registers are all 0.
- R14: `NUM_CH` must be 2 or 4. Channel n drives bit n of `wave_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| cap_strobe | input | NUM_CH | Per-channel capture trigger |
| count_o | output | CNT_W | Current count |
| bottom_o | output | 1 | Count is zero |
| top_o | output | 1 | Count equals the ceiling |
| max_o | output | 1 | Count is all ones |
| update_o | output | 1 | Update condition for the mode |
| ovf_o | output | 1 | Overflow flag |
| cmp_flag_o | output | NUM_CH | Compare-match flags |
| cap_flag_o | output | NUM_CH | Capture flags |
| wave_o | output | NUM_CH | Waveform outputs |

## Verification
Some properties are checked on every cycle. The count holds without a tick. The up-count modes wrap to 0 after the ceiling. Dual-slope turns at the ceiling with a decrement. The overflow flag is set on update ticks. The active period moves only on an update tick. A capture strobe sets the flag of a capture channel.

Other behaviour needs a whole sequence to show, and only the bench scenarios cover it. This includes the waveform shapes for each mode, the ceiling taken from channel 0, and the shadow-to-active delay seen at the read port. It also covers the priority of a load over a tick, the priority of a flag set over a clear, and a capture channel holding its value through an update.

// File: rtl/cct_pkg.sv
package cct_pkg;

   localparam int ADDR_W = 4;
   localparam int MAX_CH = 4;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_FREQ   = 2'd1,
      MODE_SSPWM  = 2'd2,
      MODE_DSPWM  = 2'd3
   } tc_mode_e;

   localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
   localparam logic [ADDR_W-1:0] A_PER     = 4'h1;
   localparam logic [ADDR_W-1:0] A_FLAG    = 4'h2;
   localparam logic [ADDR_W-1:0] A_CNT     = 4'h3;
   localparam logic [ADDR_W-1:0] A_CH_BASE = 4'h8;

   localparam int CTRL_CAP_LSB = 4;
   localparam int CTRL_OE_LSB  = 8;
   localparam int FLAG_OVF_BIT = 0;
   localparam int FLAG_CMP_LSB = 4;
   localparam int FLAG_CAP_LSB = 8;

endpackage

// File: rtl/cct_counter.sv
module cct_counter
   import cct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] top_val,
   input  tc_mode_e         mode,
   output logic [CNT_W-1:0] count,
   output logic             down,
   output logic             at_bottom,
   output logic             at_top,
   output logic             at_max,
   output logic             update
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ALL1 = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             down_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= load_val;
         down_q <= 1'b0;
      end else if (step) begin
         if (mode == MODE_DSPWM) begin
            if (!down_q) begin
               if (cnt_q >= top_val) begin
                  if (top_val == '0) begin
                     cnt_q <= '0;
                  end else begin
                     cnt_q  <= cnt_q - ONE;
                     down_q <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end else begin
               if (cnt_q == '0) begin
                  down_q <= 1'b0;
                  cnt_q  <= (top_val == '0) ? '0 : ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
         end else begin
            cnt_q <= (cnt_q == top_val) ? '0 : cnt_q + ONE;
         end
      end
   end

   assign count     = cnt_q;
   assign down      = down_q;
   assign at_bottom = (cnt_q == '0);
   assign at_top    = (cnt_q == top_val);
   assign at_max    = (cnt_q == ALL1);
   assign update    = (mode == MODE_DSPWM) ? at_bottom : at_top;

endmodule

// File: rtl/cct_regs.sv
module cct_regs
   import cct_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              upd_evt,
   output tc_mode_e          mode,
   output logic [NUM_CH-1:0] cap_sel,
   output logic [NUM_CH-1:0] oe,
   output logic [CNT_W-1:0]  per_active,
   output logic              ovf,
   output logic              load,
   output logic [NUM_CH-1:0] clr_cmp,
   output logic [NUM_CH-1:0] clr_cap
);

   tc_mode_e          mode_q;
   logic [NUM_CH-1:0] cap_sel_q;
   logic [NUM_CH-1:0] oe_q;
   logic [CNT_W-1:0]  per_buf_q;
   logic [CNT_W-1:0]  per_act_q;
   logic              ovf_q;

   logic wr_ctrl, wr_per, wr_flag;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_per  = wr_en && (wr_addr == A_PER);
   assign wr_flag = wr_en && (wr_addr == A_FLAG);
   assign load    = wr_en && (wr_addr == A_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_NORMAL;
         cap_sel_q <= '0;
         oe_q      <= '0;
      end else if (wr_ctrl) begin
         mode_q    <= tc_mode_e'(wr_data[1:0]);
         cap_sel_q <= wr_data[CTRL_CAP_LSB +: NUM_CH];
         oe_q      <= wr_data[CTRL_OE_LSB +: NUM_CH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_buf_q <= '0;
         per_act_q <= '0;
      end else begin
         if (wr_per) per_buf_q <= wr_data;
         if (upd_evt) per_act_q <= per_buf_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (upd_evt) begin
         ovf_q <= 1'b1;
      end else if (wr_flag && wr_data[FLAG_OVF_BIT]) begin
         ovf_q <= 1'b0;
      end
   end

   assign clr_cmp    = wr_flag ? wr_data[FLAG_CMP_LSB +: NUM_CH] : '0;
   assign clr_cap    = wr_flag ? wr_data[FLAG_CAP_LSB +: NUM_CH] : '0;
   assign mode       = mode_q;
   assign cap_sel    = cap_sel_q;
   assign oe         = oe_q;
   assign per_active = per_act_q;
   assign ovf        = ovf_q;

endmodule

// File: rtl/cct_channel.sv
module cct_channel
   import cct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             upd_evt,
   input  logic             wr_buf,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             clr_cmp,
   input  logic             clr_cap,
   input  logic [CNT_W-1:0] count,
   input  logic             down,
   input  tc_mode_e         mode,
   input  logic             cap_sel,
   input  logic             oe,
   input  logic             strobe,
   output logic [CNT_W-1:0] ccr,
   output logic             cmp_flag,
   output logic             cap_flag,
   output logic             wave
);

   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] ccr_q;
   logic             cmp_q, cap_q, wave_q;
   logic             eq, match, grab;

   assign eq    = (count == ccr_q);
   assign match = step && !cap_sel && eq;
   assign grab  = cap_sel && strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         ccr_q <= '0;
      end else begin
         if (wr_buf) buf_q <= wr_data;
         if (grab) begin
            ccr_q <= count;
         end else if (upd_evt && !cap_sel) begin
            ccr_q <= buf_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= 1'b0;
         cap_q <= 1'b0;
      end else begin
         if (match)        cmp_q <= 1'b1;
         else if (clr_cmp) cmp_q <= 1'b0;
         if (grab)         cap_q <= 1'b1;
         else if (clr_cap) cap_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (cap_sel) begin
         wave_q <= 1'b0;
      end else if (oe && step) begin
         unique case (mode)
            MODE_NORMAL, MODE_FREQ: begin
               if (eq) wave_q <= ~wave_q;
            end
            MODE_SSPWM: begin
               if (eq)               wave_q <= 1'b0;
               else if (count == '0) wave_q <= 1'b1;
            end
            MODE_DSPWM: begin
               if (eq) wave_q <= down;
            end
            default: wave_q <= wave_q;
         endcase
      end
   end

   assign ccr      = ccr_q;
   assign cmp_flag = cmp_q;
   assign cap_flag = cap_q;
   assign wave     = wave_q & oe & ~cap_sel;

endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import cct_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [3:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [NUM_CH-1:0] cap_strobe,
   output logic [CNT_W-1:0]  count_o,
   output logic              bottom_o,
   output logic              top_o,
   output logic              max_o,
   output logic              update_o,
   output logic              ovf_o,
   output logic [NUM_CH-1:0] cmp_flag_o,
   output logic [NUM_CH-1:0] cap_flag_o,
   output logic [NUM_CH-1:0] wave_o
);

   localparam int CTRL_USED = CTRL_OE_LSB + NUM_CH;

   if (NUM_CH != 2 && NUM_CH != MAX_CH) begin : g_bad_ch
      $error("cc_timer: NUM_CH must be 2 or 4");
   end
   if (CNT_W < FLAG_CAP_LSB + MAX_CH) begin : g_bad_w
      $error("cc_timer: CNT_W too narrow for control and flag words");
   end

   tc_mode_e                     mode_w;
   logic [NUM_CH-1:0]            cap_sel_w, oe_w, clr_cmp_w, clr_cap_w;
   logic [CNT_W-1:0]             per_act;
   logic                         cnt_load, ovf_w;
   logic [CNT_W-1:0]             top_val;
   logic                         cnt_down, update_w;
   logic                         step, upd_evt;
   logic [NUM_CH-1:0][CNT_W-1:0] ccr_w;

   assign step    = tick && !cnt_load;
   assign upd_evt = step && update_w;
   assign top_val = (mode_w == MODE_FREQ) ? ccr_w[0] : per_act;

   cct_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .upd_evt    (upd_evt),
      .mode       (mode_w),
      .cap_sel    (cap_sel_w),
      .oe         (oe_w),
      .per_active (per_act),
      .ovf        (ovf_w),
      .load       (cnt_load),
      .clr_cmp    (clr_cmp_w),
      .clr_cap    (clr_cap_w)
   );

   cct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .load      (cnt_load),
      .load_val  (wr_data),
      .top_val   (top_val),
      .mode      (mode_w),
      .count     (count_o),
      .down      (cnt_down),
      .at_bottom (bottom_o),
      .at_top    (top_o),
      .at_max    (max_o),
      .update    (update_w)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr_buf;
      assign wr_buf = wr_en && (wr_addr == A_CH_BASE + 4'(i));

      cct_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (step),
         .upd_evt  (upd_evt),
         .wr_buf   (wr_buf),
         .wr_data  (wr_data),
         .clr_cmp  (clr_cmp_w[i]),
         .clr_cap  (clr_cap_w[i]),
         .count    (count_o),
         .down     (cnt_down),
         .mode     (mode_w),
         .cap_sel  (cap_sel_w[i]),
         .oe       (oe_w[i]),
         .strobe   (cap_strobe[i]),
         .ccr      (ccr_w[i]),
         .cmp_flag (cmp_flag_o[i]),
         .cap_flag (cap_flag_o[i]),
         .wave     (wave_o[i])
      );
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL: begin
            rd_data[1:0]                      = mode_w;
            rd_data[CTRL_CAP_LSB +: NUM_CH]   = cap_sel_w;
            rd_data[CTRL_OE_LSB +: NUM_CH]    = oe_w;
         end
         A_PER: rd_data = per_act;
         A_FLAG: begin
            rd_data[FLAG_OVF_BIT]             = ovf_w;
            rd_data[FLAG_CMP_LSB +: NUM_CH]   = cmp_flag_o;
            rd_data[FLAG_CAP_LSB +: NUM_CH]   = cap_flag_o;
         end
         A_CNT: rd_data = count_o;
         default: begin
            for (int i = 0; i < NUM_CH; i++) begin
               if (rd_addr == A_CH_BASE + 4'(i)) rd_data = ccr_w[i];
            end
         end
      endcase
   end

   assign update_o = update_w;
   assign ovf_o    = ovf_w;

   if (CTRL_USED > CNT_W) begin : g_bad_ctrl
      $error("cc_timer: control word does not fit");
   end

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              load,
   input logic [1:0]        mode,
   input logic [CNT_W-1:0]  count,
   input logic              at_top,
   input logic              update,
   input logic              ovf,
   input logic [CNT_W-1:0]  per_active,
   input logic [NUM_CH-1:0] cap_sel,
   input logic [NUM_CH-1:0] cap_strobe,
   input logic [NUM_CH-1:0] cap_flag
);

   // R1
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));

   // R1
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && mode != 2'd3 && at_top) |=> (count == '0));

   // R3
   dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && mode == 2'd3 && at_top && count != '0 && !$isunknown(count))
      |=> (count == $past(count) - 1'b1));

   // R6
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && update) |=> ovf);

   // R5
   per_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && !load && update) |=> $stable(per_active));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_cap
      // R11
      cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_sel[i] && cap_strobe[i]) |=> cap_flag[i]);
   end

endmodule

bind cc_timer cct_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .load       (cnt_load),
   .mode       (mode_w),
   .count      (count_o),
   .at_top     (top_o),
   .update     (update_o),
   .ovf        (ovf_o),
   .per_active (per_act),
   .cap_sel    (cap_sel_w),
   .cap_strobe (cap_strobe),
   .cap_flag   (cap_flag_o)
);

// File: tb/tb_cc_timer.sv
module tb_cc_timer;

   localparam int CNT_W  = 16;
   localparam int NUM_CH = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              wr_en = 1'b0;
   logic [3:0]        wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [3:0]        rd_addr = '0;
   logic [CNT_W-1:0]  rd_data;
   logic [NUM_CH-1:0] cap_strobe = '0;
   logic [CNT_W-1:0]  count_o;
   logic              bottom_o, top_o, max_o, update_o, ovf_o;
   logic [NUM_CH-1:0] cmp_flag_o, cap_flag_o, wave_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cc_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cap_strobe(cap_strobe), .count_o(count_o), .bottom_o(bottom_o),
      .top_o(top_o), .max_o(max_o), .update_o(update_o), .ovf_o(ovf_o),
      .cmp_flag_o(cmp_flag_o), .cap_flag_o(cap_flag_o), .wave_o(wave_o)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [15:0] per;
      logic [15:0] cmp;
      logic [7:0]  ticks;
      logic [15:0] exp_cnt;
      logic        exp_wave;
      logic        exp_ovf;
      logic        exp_cmpf;
   } vec_t;

   // mode, period, ch0 compare, ticks -> count, wave0, ovf, cmp flag0
   localparam vec_t VECS [9] = '{
      '{2'd0, 16'd9,   16'd3, 8'd5, 16'd5, 1'b1, 1'b0, 1'b1},
      '{2'd0, 16'd4,   16'd2, 8'd7, 16'd2, 1'b1, 1'b1, 1'b1},
      '{2'd1, 16'd100, 16'd3, 8'd6, 16'd2, 1'b1, 1'b1, 1'b1},
      '{2'd2, 16'd7,   16'd3, 8'd2, 16'd2, 1'b1, 1'b0, 1'b0},
      '{2'd2, 16'd7,   16'd3, 8'd5, 16'd5, 1'b0, 1'b0, 1'b1},
      '{2'd2, 16'd7,   16'd3, 8'd9, 16'd1, 1'b1, 1'b1, 1'b1},
      '{2'd3, 16'd4,   16'd2, 8'd3, 16'd3, 1'b0, 1'b1, 1'b1},
      '{2'd3, 16'd4,   16'd2, 8'd7, 16'd1, 1'b1, 1'b1, 1'b1},
      '{2'd3, 16'd4,   16'd2, 8'd9, 16'd1, 1'b1, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // R13 / R4: reset state
      do_reset();
      check("R13 count", count_o, 0);
      check("R13 ovf", ovf_o, 0);
      check("R13 flags", {cmp_flag_o, cap_flag_o}, 0);
      check("R13 wave", wave_o, 0);
      rd_addr = 4'h1; #1;
      check("R13 period", rd_data, 0);
      check("R4 bottom/top/update at reset", {bottom_o, top_o, update_o, max_o}, 4'b1110);

      // vector table: R1 R2 R3 R7 R8 R9 R10
      for (int v = 0; v < 9; v++) begin
         do_reset();
         wr(4'h1, VECS[v].per);
         wr(4'h8, VECS[v].cmp);
         run(1);
         wr(4'h0, {7'd0, 1'b1, 6'd0, VECS[v].mode});
         wr(4'h2, 16'hFFFF);
         run(int'(VECS[v].ticks));
         check($sformatf("R1/R2/R3 vec%0d count", v), count_o, VECS[v].exp_cnt);
         check($sformatf("R8/R9/R10 vec%0d wave", v), wave_o[0], VECS[v].exp_wave);
         check($sformatf("R6 vec%0d ovf", v), ovf_o, VECS[v].exp_ovf);
         check($sformatf("R7 vec%0d cmp flag", v), cmp_flag_o[0], VECS[v].exp_cmpf);
      end

      // R4 / R12 / R1: all-ones independent of ceiling
      do_reset();
      wr(4'h1, 16'd9);
      run(1);
      wr(4'h3, 16'hFFFF);
      check("R4 max at FFFF", {max_o, top_o, bottom_o, update_o}, 4'b1000);
      check("R12 load", count_o, 16'hFFFF);
      run(1);
      check("R1 roll past all-ones", count_o, 0);
      wr(4'h2, 16'hFFFF);
      wr(4'h3, 16'd9);
      check("R4 top and update", {top_o, update_o}, 2'b11);
      run(1);
      check("R1 wrap at top", count_o, 0);
      check("R6 ovf set", ovf_o, 1);
      wr(4'h2, 16'h0001);
      check("R6 ovf cleared", ovf_o, 0);
      // R6 set wins over clear
      wr(4'h3, 16'd9);
      tick = 1'b1;
      wr(4'h2, 16'h0001);
      tick = 1'b0;
      check("R6 set beats clear", ovf_o, 1);

      // R5: shadow behaviour
      wr(4'h1, 16'd5);
      wr(4'h8, 16'd4);
      rd_addr = 4'h1; #1;
      check("R5 period held", rd_data, 9);
      rd_addr = 4'h8; #1;
      check("R5 compare held", rd_data, 0);
      run(3);
      rd_addr = 4'h1; #1;
      check("R5 period held mid-period", rd_data, 9);
      wr(4'h3, 16'd9);
      run(1);
      #1;
      check("R5 period copied", rd_data, 5);
      rd_addr = 4'h8; #1;
      check("R5 compare copied", rd_data, 4);

      // R12: load overrides tick
      tick = 1'b1;
      wr(4'h3, 16'd7);
      tick = 1'b0;
      check("R12 load beats tick", count_o, 7);

      // R11: capture
      do_reset();
      wr(4'h1, 16'd50);
      run(1);
      wr(4'h0, 16'h0220);
      run(6);
      check("R1 count before capture", count_o, 6);
      cap_strobe = 4'b0010;
      @(negedge clk);
      cap_strobe = '0;
      rd_addr = 4'h9; #1;
      check("R11 captured value", rd_data, 6);
      check("R11 capture flag", cap_flag_o[1], 1);
      check("R11 capture wave low", wave_o[1], 0);
      wr(4'h9, 16'd33);
      wr(4'h3, 16'd50);
      run(1);
      #1;
      check("R11 capture ignores shadow", rd_data, 6);
      wr(4'h2, 16'h0200);
      check("R11 capture flag cleared", cap_flag_o[1], 0);
      cap_strobe = 4'b0010;
      wr(4'h2, 16'h0200);
      cap_strobe = '0;
      check("R11 capture set beats clear", cap_flag_o[1], 1);

      // R14 / R9: output bit order, single-slope on channel 2
      do_reset();
      wr(4'h1, 16'd20);
      wr(4'hA, 16'd5);
      run(1);
      wr(4'h0, 16'h0402);
      run(1);
      check("R14 ch2 on bit 2", wave_o, 4'b0100);
      run(4);
      check("R9 held until match", wave_o, 4'b0100);
      run(1);
      check("R9 cleared at match", wave_o, 4'b0000);
      check("R7 ch2 flag", cmp_flag_o[2], 1);

      finish_run();
   end

endmodule